// File: doc/BRIEF.md
# SIMD Widening Odd-Even Add/Subtract Unit

This block executes one family of vector arithmetic operations on 128-bit operands. Each operation takes narrow elements from two source vectors, widens them to twice their width, and adds or subtracts them. Result lane i always combines element 2i+1 of the first source with element 2i of the second source, so the unit pairs odd elements with even elements instead of working lane by lane. Element 0 sits in the least significant bits of every vector.

The unit decodes a 32-bit instruction word into one of sixteen operations. Each operation is a choice of add or subtract, signed or unsigned, and one of four source widths from 8 to 64 bits. Words outside the family are flagged as illegal and give a zero result. The three register index fields of the word are passed through for the surrounding pipeline. The unit has a single register stage, and every output shows the inputs present at the previous rising clock edge.

Top module: `wdn_oddeven_unit`

## Requirements
- R1: While rst_n is low at a rising edge, every output is cleared to zero: the result, both flags and all three indices.
- R2: A word is legal exactly when bits [31:20] equal 0111_0000_0101 and the function field [19:18] is 01 (signed) or 10 (unsigned). Bit [17] set means subtract and clear means add. Bits [16:15] select the source width: 00 is 8 bits, 01 is 16 bits, 10 is 32 bits and 11 is 64 bits. For a legal word, op_ok is 1 and op_bad is 0.
- R3: For source width W, result lane i (bits [2W*i +: 2W]) equals ext(src_j[W*(2i+1) +: W]) op ext(src_k[W*2i +: W]), giving 8, 4, 2 or 1 lanes.
- R4: Signed operations sign-extend both narrow operands to 2W bits before the operation. Unsigned operations zero-extend them.
- R5: Subtraction takes the src_j element as the minuend and the src_k element as the subtrahend. The result wraps modulo 2^(2W) and does not saturate.
- R6: At source width 64 the result is a single 128-bit lane formed from src_j[127:64] and src_k[63:0].
- R7: An illegal word gives op_bad=1, op_ok=0 and res=0.
- R8: idx_d, idx_j and idx_k carry instruction bits [4:0], [9:5] and [14:10], whether or not the word is legal.
- R9: Every output changes only at a rising edge and reflects the inputs sampled at that edge, so the latency is one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn | input | 32 | Instruction word |
| src_j | input | 128 | First source vector; supplies the odd elements |
| src_k | input | 128 | Second source vector; supplies the even elements |
| res | output | 128 | Destination vector |
| op_ok | output | 1 | Word decoded as one of the sixteen operations |
| op_bad | output | 1 | Word not in the family |
| idx_d | output | 5 | Destination register index |
| idx_j | output | 5 | First source register index |
| idx_k | output | 5 | Second source register index |

## Verification
The hardest cases to reach are those where extension changes the result. These need the sign bit of the odd src_j element and the sign bit of the even src_k element to differ, and they need the carry or borrow to cross into the widened upper half. Uniform random data rarely lines these up in every lane at once. The stimulus therefore fills every element of each width with the most negative value, the most positive value, all ones or zero, and crosses those fills between the two sources for all sixteen codes. Random vectors under every code and illegal words then cover the remaining mix. Illegal words come from near misses: the two unused function groups and a single flipped prefix bit.

// File: rtl/wdn_pkg.sv
// Shared types for the widening odd-even unit.
// Assumes a fixed 128-bit vector and a 32-bit instruction word.
package wdn_pkg;
    localparam int VLEN      = 128;
    localparam int ILEN      = 32;
    localparam int NSIZE     = 4;
    localparam int IDXW      = 5;
    localparam logic [11:0] FAMILY_TAG = 12'b0111_0000_0101;

    typedef struct packed {
        logic       legal;
        logic       sgn;
        logic       sub;
        logic [1:0] size;
    } wdn_op_t;
endpackage

// File: rtl/wdn_decode.sv
// Instruction decoder: recognises the sixteen-operation family and splits
// the function field into sign, add/subtract and width selection.
// Assumes the word is stable during the cycle; purely combinational.
module wdn_decode
    import wdn_pkg::*;
(
    input  logic [ILEN-1:0] insn,
    output wdn_op_t         op
);
    logic [1:0] grp;

    // Classify the word and unpack the function field.
    always_comb begin
        grp      = insn[19:18];
        op.legal = (insn[31:20] == FAMILY_TAG) && (grp == 2'b01 || grp == 2'b10);
        op.sgn   = (grp == 2'b01);
        op.sub   = insn[17];
        op.size  = insn[16:15];
    end

    // Immediate check: a legal decode always carries the family tag (R2)
    always_comb begin
        if (op.legal) begin
            // R2
            legal_tag_chk: assert (insn[31:20] == FAMILY_TAG);
        end
    end
endmodule

// File: rtl/wdn_datapath.sv
// Lane arithmetic: for every width, pairs odd src_j elements with even
// src_k elements, extends them and adds or subtracts; then picks one width.
// Assumes element 0 sits at the least significant bits. Combinational.
module wdn_datapath
    import wdn_pkg::*;
#(
    parameter int VW = VLEN
) (
    input  logic [VW-1:0] src_j,
    input  logic [VW-1:0] src_k,
    input  logic          sgn,
    input  logic          sub,
    input  logic [1:0]    size,
    output logic [VW-1:0] res
);
    logic [VW-1:0] per_size [NSIZE];

    for (genvar s = 0; s < NSIZE; s++) begin : g_size
        localparam int EW = 8 << s;
        localparam int RW = 2 * EW;
        localparam int NL = VW / RW;
        for (genvar i = 0; i < NL; i++) begin : g_lane
            logic [EW-1:0] a_n, b_n;
            logic [RW-1:0] a_w, b_w;
            // Extend the odd/even narrow pair and combine into one lane.
            always_comb begin
                a_n = src_j[EW*(2*i+1) +: EW];
                b_n = src_k[EW*(2*i)   +: EW];
                a_w = {{EW{sgn & a_n[EW-1]}}, a_n};
                b_w = {{EW{sgn & b_n[EW-1]}}, b_n};
                per_size[s][RW*i +: RW] = sub ? (a_w - b_w) : (a_w + b_w);
            end
        end
    end

    // Select the lane set for the decoded width.
    always_comb res = per_size[size];

    // Unsigned add of two 64-bit values cannot reach bit 65 (R6)
    always_comb begin
        if (!sgn && !sub && size == 2'd3) begin
            // R6
            wide_uadd_range_chk: assert (res[VW-1:65] == '0);
        end
    end
endmodule

// File: rtl/wdn_oddeven_unit.sv
// Top: decodes the word, runs the lane datapath and registers the result,
// flags and index fields once per cycle. Illegal words yield a zero result.
// Assumes synchronous active-low reset; no handshake at the edge.
module wdn_oddeven_unit
    import wdn_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ILEN-1:0]  insn,
    input  logic [VLEN-1:0]  src_j,
    input  logic [VLEN-1:0]  src_k,
    output logic [VLEN-1:0]  res,
    output logic             op_ok,
    output logic             op_bad,
    output logic [IDXW-1:0]  idx_d,
    output logic [IDXW-1:0]  idx_j,
    output logic [IDXW-1:0]  idx_k
);
    wdn_op_t         op;
    logic [VLEN-1:0] lane_res;

    wdn_decode u_dec (
        .insn (insn),
        .op   (op)
    );

    wdn_datapath #(.VW(VLEN)) u_dp (
        .src_j (src_j),
        .src_k (src_k),
        .sgn   (op.sgn),
        .sub   (op.sub),
        .size  (op.size),
        .res   (lane_res)
    );

    // Output register stage with zeroing for illegal words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res    <= '0;
            op_ok  <= 1'b0;
            op_bad <= 1'b0;
            idx_d  <= '0;
            idx_j  <= '0;
            idx_k  <= '0;
        end else begin
            res    <= op.legal ? lane_res : '0;
            op_ok  <= op.legal;
            op_bad <= ~op.legal;
            idx_d  <= insn[4:0];
            idx_j  <= insn[9:5];
            idx_k  <= insn[14:10];
        end
    end

    // R7
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (op_ok ^ op_bad));

    // R7
    bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_bad |-> (res == '0));

    // R2
    ok_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_ok |-> ($past(insn[31:20]) == FAMILY_TAG));

    // R8
    idx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (idx_d == $past(insn[4:0]) && idx_j == $past(insn[9:5])
                          && idx_k == $past(insn[14:10])));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (res == '0 && !op_ok && !op_bad));
endmodule

// File: tb/tb_wdn_oddeven_unit.sv
module tb_wdn_oddeven_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  insn = '0;
    logic [127:0] src_j = '0, src_k = '0;
    logic [127:0] res;
    logic         op_ok, op_bad;
    logic [4:0]   idx_d, idx_j, idx_k;

    int n_chk = 0;
    int n_bad = 0;

    wdn_oddeven_unit dut (
        .clk(clk), .rst_n(rst_n), .insn(insn), .src_j(src_j), .src_k(src_k),
        .res(res), .op_ok(op_ok), .op_bad(op_bad),
        .idx_d(idx_d), .idx_j(idx_j), .idx_k(idx_k)
    );

    always #4 clk = ~clk;

    initial begin
        #1500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    function automatic logic [31:0] mk_word(input logic [4:0] fn, input logic [14:0] regs);
        return {12'b0111_0000_0101, fn, regs};
    endfunction

    function automatic logic [127:0] ref_res(input logic [31:0] w, input logic [127:0] j,
                                             input logic [127:0] k);
        logic [127:0] out, em, rm, a, b, r;
        int ew, n;
        bit sg, sb;
        out = '0;
        if (w[31:20] != 12'b0111_0000_0101 || !(w[19:18] == 2'b01 || w[19:18] == 2'b10))
            return '0;
        sg = (w[19:18] == 2'b01);
        sb = w[17];
        ew = 8 << w[16:15];
        n  = 128 / (2 * ew);
        em = {128{1'b1}} >> (128 - ew);
        rm = {128{1'b1}} >> (128 - 2 * ew);
        for (int i = 0; i < n; i++) begin
            a = (j >> (ew * (2 * i + 1))) & em;
            b = (k >> (ew * (2 * i))) & em;
            if (sg && a[ew-1]) a = a | ~em;
            if (sg && b[ew-1]) b = b | ~em;
            r = sb ? a - b : a + b;
            out = out | ((r & rm) << (2 * ew * i));
        end
        return out;
    endfunction

    function automatic logic [127:0] fill(input int sz, input int kind);
        logic [127:0] v, e;
        int ew;
        ew = 8 << sz;
        case (kind)
            0: e = 128'd1 << (ew - 1);
            1: e = ({128{1'b1}} >> (128 - ew)) >> 1;
            2: e = {128{1'b1}} >> (128 - ew);
            default: e = '0;
        endcase
        v = '0;
        for (int i = 0; i < 128 / ew; i++) v = v | (e << (ew * i));
        return v;
    endfunction

    function automatic string tag_of(input logic [4:0] fn);
        if (fn[1:0] == 2'd3) return "R6";
        if (fn[2]) return "R5";
        if (fn[4:3] == 2'b01) return "R4";
        return "R3";
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at negedge; the result is registered at the next posedge and sampled at the following negedge.
    task automatic run(input logic [31:0] w, input logic [127:0] j, input logic [127:0] k);
        logic legal;
        insn = w; src_j = j; src_k = k;
        @(negedge clk);
        legal = (w[31:20] == 12'b0111_0000_0101) && (w[19:18] == 2'b01 || w[19:18] == 2'b10);
        check(legal ? tag_of(w[19:15]) : "R7", res, ref_res(w, j, k));
        check(legal ? "R2" : "R7", {126'd0, op_ok, op_bad}, {126'd0, legal, ~legal});
        check("R8", {113'd0, idx_d, idx_j, idx_k}, {113'd0, w[4:0], w[9:5], w[14:10]});
    endtask

    initial begin
        logic [127:0] prev;
        process::self().srandom(32'd20240611);
        @(negedge clk);
        insn = mk_word(5'b01000, 15'h1234);
        src_j = '1; src_k = '1;
        @(negedge clk);
        // R1: outputs cleared under reset
        check("R1", {res, op_ok, op_bad, idx_d, idx_j, idx_k}, '0);
        rst_n = 1'b1;

        // Directed single-lane cases.
        run(mk_word(5'b01011, 15'h0), {64'h8000_0000_0000_0000, 64'h0}, {64'h0, 64'h7fff_ffff_ffff_ffff});
        run(mk_word(5'b10111, 15'h0), {64'h0, 64'hffff}, {64'h0, 64'h1});
        run(mk_word(5'b01100, 15'h7fff), {16{8'h80}}, {16{8'h7f}});

        // Corner fills crossed between the sources, all sixteen codes.
        for (int g = 1; g <= 2; g++)
            for (int op = 0; op < 8; op++)
                for (int ka = 0; ka < 4; ka++)
                    for (int kb = 0; kb < 4; kb++)
                        run(mk_word({g[1:0], op[2:0]}, 15'($urandom)),
                            fill(op % 4, ka), fill(op % 4, kb));

        // Random vectors on every code.
        for (int r = 0; r < 40; r++)
            for (int g = 1; g <= 2; g++)
                for (int op = 0; op < 8; op++)
                    run(mk_word({g[1:0], op[2:0]}, 15'($urandom)),
                        {$urandom, $urandom, $urandom, $urandom},
                        {$urandom, $urandom, $urandom, $urandom});

        // R7: unused groups and flipped prefix bits.
        for (int op = 0; op < 8; op++) begin
            run(mk_word({2'b00, op[2:0]}, 15'($urandom)), '1, '1);
            run(mk_word({2'b11, op[2:0]}, 15'($urandom)), '1, 128'd5);
        end
        for (int b = 20; b < 32; b++)
            run(mk_word(5'b10000, 15'h2aaa) ^ (32'd1 << b), '1, '1);

        // R9: output holds until the next rising edge.
        run(mk_word(5'b10000, 15'h0), {16{8'h01}}, {16{8'h01}});
        prev = res;
        insn = mk_word(5'b10100, 15'h0); src_j = '1; src_k = '0;
        #2;
        check("R9", res, prev);
        @(negedge clk);
        check("R9", res, ref_res(insn, src_j, src_k));

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule